// File: doc/BRIEF.md
# Inflight Packet Credit Release Unit

This block holds the load-balancing credit counters of a packet ingress engine: one inflight-packet count per bucket and one per notification ring. A dispatcher bumps both counters through an increment port each time it assigns a packet. Software returns credits with a single memory-mapped store. The store's address carries the target: a region code, a ring index, a bucket index, one enable bit for each of the two counter kinds, and a service-domain index. The data word carries the number of packets being released.

A store is accepted only when its region code matches, at least one enable is set, and its service domain is enabled in a 32-bit domain mask. An accepted store subtracts the release count from the addressed bucket, from the addressed ring, or from both. A counter never wraps. A release larger than the count floors the counter at zero and latches an underflow flag. An increment on a full counter holds it at all ones.

A table port reads and writes each bucket's status entry, which holds the assigned ring, the inflight count, a group and a mode. Software uses it to initialize the buckets. A read port returns the count of a selected ring.

Top module: `credit_release_unit`

## Requirements
- R1: Store address fields: ring index in bits [10:3], bucket index in [23:11], ring enable in [24], bucket enable in [25], region in [28:26], service domain in [39:35]. The release count is data bits [15:0]. All other address and data bits have no effect.
- R2: A store whose region field is not 4 changes no counter and does not set the underflow flag.
- R3: A store with region 4 but both enable bits clear changes no counter.
- R4: An accepted store with the bucket enable set subtracts the release count from the addressed bucket's count. With the ring enable set it subtracts the count from the addressed ring. With both set, both counters are updated by the same store.
- R5: A store is accepted only when bit `domain` of `dom_en_i` is set. Otherwise it has no effect.
- R6: An increment pulse adds one to the selected bucket count and one to the selected ring count. A counter already at 16'hFFFF stays there.
- R7: A release larger than the sum of the current count and any same-cycle increment sets the counter to zero and sets `underflow_o`. The flag stays set until reset.
- R8: When an increment and a release reach the same counter in one cycle, the counter becomes count + 1 − release, applied as a single update. It flags underflow only if that result would be negative.
- R9: Bucket entry layout: assigned ring [7:0], count [23:8], group [28:24], mode [31:29]. A table write replaces the whole entry and takes priority over a same-cycle increment or release of that bucket. `tbl_rdata_o` shows entry `tbl_idx_i` one cycle after the index is presented.
- R10: `ring_cnt_o` shows the count of ring `ring_sel_i` one cycle after the selection is presented.
- R11: After reset every bucket entry, every ring count and `underflow_o` are zero.
- R12: A store whose bucket index is at or above the bucket count, or whose ring index is at or above the ring count, touches no bucket or ring respectively. In particular it does not alias onto a lower index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mmio_wr_i | input | 1 | Release store strobe |
| mmio_addr_i | input | 40 | Store address with target fields |
| mmio_data_i | input | 64 | Store data, release count in [15:0] |
| dom_en_i | input | 32 | Per-service-domain store enable mask |
| inc_i | input | 1 | Dispatch increment strobe |
| inc_bkt_i | input | BKT_SEL_W | Bucket to increment |
| inc_ring_i | input | RING_SEL_W | Ring to increment |
| tbl_we_i | input | 1 | Bucket entry write strobe |
| tbl_idx_i | input | BKT_SEL_W | Bucket entry index for read and write |
| tbl_wdata_i | input | 32 | Bucket entry write data |
| tbl_rdata_o | output | 32 | Bucket entry read data |
| ring_sel_i | input | RING_SEL_W | Ring count read select |
| ring_cnt_o | output | 16 | Ring count read data |
| underflow_o | output | 1 | Sticky release underflow flag |

## Verification
A store, increment or table write is applied at the clock edge that samples it. The new count is first visible through a read issued in the following cycle. That read's data arrives one edge later. `underflow_o` changes at the same edge as the counter. The bench drives each operation for exactly one edge and only then issues reads. Each read pushes its expected value, taken from a bench model, into a queue tagged with the cycle in which the data is due. The monitor compares each item at the falling clock edge of that cycle, so every result is sampled one edge after the read.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int unsigned ADDR_W      = 40;
  localparam int unsigned DATA_W      = 64;
  localparam int unsigned CNT_W       = 16;
  localparam int unsigned ENT_W       = 32;
  localparam int unsigned DOM_N       = 32;
  localparam int unsigned A_RING_LSB  = 3;
  localparam int unsigned A_BKT_LSB   = 11;
  localparam int unsigned A_RING_EN   = 24;
  localparam int unsigned A_BKT_EN    = 25;
  localparam int unsigned A_REG_LSB   = 26;
  localparam int unsigned A_DOM_LSB   = 35;
  localparam logic [2:0]  REL_REGION  = 3'd4;

  typedef struct packed {
    logic [4:0]  dom;
    logic [2:0]  region;
    logic        bkt_en;
    logic        ring_en;
    logic [12:0] bkt;
    logic [7:0]  ring;
  } rel_addr_t;

  typedef struct packed {
    logic [2:0]       mode;
    logic [4:0]       group;
    logic [CNT_W-1:0] count;
    logic [7:0]       ring;
  } bkt_entry_t;
endpackage

// File: rtl/crd_addr_dec.sv
module crd_addr_dec
  import crd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output rel_addr_t         dec_o
);
  assign dec_o.ring    = addr_i[A_RING_LSB +: 8];
  assign dec_o.bkt     = addr_i[A_BKT_LSB +: 13];
  assign dec_o.ring_en = addr_i[A_RING_EN];
  assign dec_o.bkt_en  = addr_i[A_BKT_EN];
  assign dec_o.region  = addr_i[A_REG_LSB +: 3];
  assign dec_o.dom     = addr_i[A_DOM_LSB +: 5];

  // reserved address bits
  logic unused_rsvd;
  assign unused_rsvd = ^{addr_i[A_RING_LSB-1:0], addr_i[A_DOM_LSB-1:A_REG_LSB+3]};
endmodule

// File: rtl/crd_sat_upd.sv
module crd_sat_upd #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic         inc_i,
  input  logic [W-1:0] rel_i,
  output logic [W-1:0] nxt_o,
  output logic         uflow_o
);
  logic [W:0] sum, diff;

  always_comb begin
    sum     = {1'b0, cnt_i} + {{W{1'b0}}, inc_i};
    diff    = sum - {1'b0, rel_i};
    uflow_o = sum < {1'b0, rel_i};
    if (uflow_o)     nxt_o = '0;
    else if (diff[W]) nxt_o = '1;
    else             nxt_o = diff[W-1:0];
  end
endmodule

// File: rtl/credit_release_unit.sv
module credit_release_unit
  import crd_pkg::*;
#(
  parameter  int unsigned NUM_BKT    = 16,
  parameter  int unsigned NUM_RING   = 8,
  localparam int unsigned BKT_SEL_W  = (NUM_BKT > 1) ? $clog2(NUM_BKT) : 1,
  localparam int unsigned RING_SEL_W = (NUM_RING > 1) ? $clog2(NUM_RING) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mmio_wr_i,
  input  logic [ADDR_W-1:0]     mmio_addr_i,
  input  logic [DATA_W-1:0]     mmio_data_i,
  input  logic [DOM_N-1:0]      dom_en_i,
  input  logic                  inc_i,
  input  logic [BKT_SEL_W-1:0]  inc_bkt_i,
  input  logic [RING_SEL_W-1:0] inc_ring_i,
  input  logic                  tbl_we_i,
  input  logic [BKT_SEL_W-1:0]  tbl_idx_i,
  input  logic [ENT_W-1:0]      tbl_wdata_i,
  output logic [ENT_W-1:0]      tbl_rdata_o,
  input  logic [RING_SEL_W-1:0] ring_sel_i,
  output logic [CNT_W-1:0]      ring_cnt_o,
  output logic                  underflow_o
);
  rel_addr_t dec;
  logic [CNT_W-1:0] rel_cnt;
  logic acc;

  crd_addr_dec u_dec (.addr_i(mmio_addr_i), .dec_o(dec));

  assign rel_cnt = mmio_data_i[CNT_W-1:0];
  logic unused_data;
  assign unused_data = ^mmio_data_i[DATA_W-1:CNT_W];

  assign acc = mmio_wr_i && (dec.region == REL_REGION) &&
               (dec.bkt_en || dec.ring_en) && dom_en_i[dec.dom];

  bkt_entry_t [NUM_BKT-1:0]               tbl;
  logic       [NUM_BKT-1:0][CNT_W-1:0]    bkt_cnt;
  logic       [NUM_RING-1:0][CNT_W-1:0]   ring_cnt;
  logic       [NUM_BKT-1:0]               bkt_uf;
  logic       [NUM_RING-1:0]              ring_uf;

  for (genvar b = 0; b < NUM_BKT; b++) begin : g_bkt
    bkt_entry_t       ent_q;
    logic             hit_rel, hit_inc, hit_wr, uf_raw;
    logic [CNT_W-1:0] nxt;

    assign hit_rel = acc && dec.bkt_en && (dec.bkt == 13'(b));
    assign hit_inc = inc_i && (inc_bkt_i == BKT_SEL_W'(b));
    assign hit_wr  = tbl_we_i && (tbl_idx_i == BKT_SEL_W'(b));

    crd_sat_upd #(.W(CNT_W)) u_upd (
      .cnt_i  (ent_q.count),
      .inc_i  (hit_inc),
      .rel_i  (hit_rel ? rel_cnt : '0),
      .nxt_o  (nxt),
      .uflow_o(uf_raw)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q <= '0;
      else if (hit_wr) ent_q <= tbl_wdata_i;
      else             ent_q.count <= nxt;
    end

    assign bkt_uf[b]  = uf_raw && !hit_wr;
    assign tbl[b]     = ent_q;
    assign bkt_cnt[b] = ent_q.count;
  end

  for (genvar r = 0; r < NUM_RING; r++) begin : g_ring
    logic [CNT_W-1:0] cnt_q, nxt;
    logic             hit_rel, hit_inc;

    assign hit_rel = acc && dec.ring_en && (dec.ring == 8'(r));
    assign hit_inc = inc_i && (inc_ring_i == RING_SEL_W'(r));

    crd_sat_upd #(.W(CNT_W)) u_upd (
      .cnt_i  (cnt_q),
      .inc_i  (hit_inc),
      .rel_i  (hit_rel ? rel_cnt : '0),
      .nxt_o  (nxt),
      .uflow_o(ring_uf[r])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= nxt;
    end

    assign ring_cnt[r] = cnt_q;
  end

  logic [ENT_W-1:0] rdata_q;
  logic [CNT_W-1:0] rcnt_q;
  logic             uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rcnt_q  <= '0;
      uf_q    <= 1'b0;
    end else begin
      rdata_q <= (32'(tbl_idx_i) < NUM_BKT) ? tbl[tbl_idx_i] : '0;
      rcnt_q  <= (32'(ring_sel_i) < NUM_RING) ? ring_cnt[ring_sel_i] : '0;
      uf_q    <= uf_q || (|bkt_uf) || (|ring_uf);
    end
  end

  assign tbl_rdata_o = rdata_q;
  assign ring_cnt_o  = rcnt_q;
  assign underflow_o = uf_q;
endmodule

// File: rtl/credit_release_unit_chk.sv
module credit_release_unit_chk
  import crd_pkg::*;
#(
  parameter  int unsigned NUM_BKT    = 16,
  parameter  int unsigned NUM_RING   = 8,
  localparam int unsigned BKT_SEL_W  = (NUM_BKT > 1) ? $clog2(NUM_BKT) : 1,
  localparam int unsigned RING_SEL_W = (NUM_RING > 1) ? $clog2(NUM_RING) : 1
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            mmio_wr_i,
  input logic [ADDR_W-1:0]               mmio_addr_i,
  input logic [DATA_W-1:0]               mmio_data_i,
  input logic [DOM_N-1:0]                dom_en_i,
  input logic                            inc_i,
  input logic                            tbl_we_i,
  input logic                            underflow_o,
  input logic [NUM_BKT-1:0][CNT_W-1:0]   bkt_cnt_i,
  input logic [NUM_RING-1:0][CNT_W-1:0]  ring_cnt_i
);
  logic [2:0]            region;
  logic                  b_en, r_en, quiet, acc;
  logic [4:0]            dom;
  logic [7:0]            r_idx;
  logic [12:0]           b_idx;
  logic [CNT_W-1:0]      rel;
  logic [BKT_SEL_W-1:0]  b_sel;
  logic [RING_SEL_W-1:0] r_sel;

  assign region = mmio_addr_i[A_REG_LSB +: 3];
  assign b_en   = mmio_addr_i[A_BKT_EN];
  assign r_en   = mmio_addr_i[A_RING_EN];
  assign dom    = mmio_addr_i[A_DOM_LSB +: 5];
  assign r_idx  = mmio_addr_i[A_RING_LSB +: 8];
  assign b_idx  = mmio_addr_i[A_BKT_LSB +: 13];
  assign rel    = mmio_data_i[CNT_W-1:0];
  assign b_sel  = b_idx[BKT_SEL_W-1:0];
  assign r_sel  = r_idx[RING_SEL_W-1:0];
  assign quiet  = !inc_i && !tbl_we_i;
  assign acc    = mmio_wr_i && (region == REL_REGION) && dom_en_i[dom] && (b_en || r_en);

  AST_UFLOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o); // R7

  AST_REGION_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_wr_i && (region != REL_REGION) && quiet
    |=> $stable(bkt_cnt_i) && $stable(ring_cnt_i)); // R2

  AST_NO_ENABLE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_wr_i && !b_en && !r_en && quiet
    |=> $stable(bkt_cnt_i) && $stable(ring_cnt_i)); // R3

  AST_DOM_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_wr_i && !dom_en_i[dom] && quiet
    |=> $stable(bkt_cnt_i) && $stable(ring_cnt_i)); // R5

  AST_RING_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && r_en && (32'(r_idx) < NUM_RING) && quiet && (rel <= ring_cnt_i[r_sel])
    |=> ring_cnt_i[$past(r_sel)] == $past(ring_cnt_i[r_sel]) - $past(rel)); // R4

  AST_BKT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && b_en && (32'(b_idx) < NUM_BKT) && quiet && (rel > bkt_cnt_i[b_sel])
    |=> (bkt_cnt_i[$past(b_sel)] == '0) && underflow_o); // R7
endmodule

bind credit_release_unit credit_release_unit_chk #(
  .NUM_BKT (NUM_BKT),
  .NUM_RING(NUM_RING)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mmio_wr_i  (mmio_wr_i),
  .mmio_addr_i(mmio_addr_i),
  .mmio_data_i(mmio_data_i),
  .dom_en_i   (dom_en_i),
  .inc_i      (inc_i),
  .tbl_we_i   (tbl_we_i),
  .underflow_o(underflow_o),
  .bkt_cnt_i  (bkt_cnt),
  .ring_cnt_i (ring_cnt)
);

// File: tb/credit_release_unit_tb_top.sv
module credit_release_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mmio_wr_i = 1'b0;
  logic [39:0] mmio_addr_i = '0;
  logic [63:0] mmio_data_i = '0;
  logic [31:0] dom_en_i = 32'hFFFF_FDFE;
  logic        inc_i = 1'b0;
  logic [3:0]  inc_bkt_i = '0;
  logic [2:0]  inc_ring_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_idx_i = '0;
  logic [31:0] tbl_wdata_i = '0;
  logic [31:0] tbl_rdata_o;
  logic [2:0]  ring_sel_i = '0;
  logic [15:0] ring_cnt_o;
  logic        underflow_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  credit_release_unit #(.NUM_BKT(NB), .NUM_RING(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mmio_wr_i(mmio_wr_i), .mmio_addr_i(mmio_addr_i),
    .mmio_data_i(mmio_data_i), .dom_en_i(dom_en_i), .inc_i(inc_i),
    .inc_bkt_i(inc_bkt_i), .inc_ring_i(inc_ring_i), .tbl_we_i(tbl_we_i),
    .tbl_idx_i(tbl_idx_i), .tbl_wdata_i(tbl_wdata_i), .tbl_rdata_o(tbl_rdata_o),
    .ring_sel_i(ring_sel_i), .ring_cnt_o(ring_cnt_o), .underflow_o(underflow_o)
  );

  typedef struct {
    int          due;
    int          kind;   // 0 entry, 1 ring count, 2 underflow
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  item_t       mon_it;
  logic [31:0] mon_got;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  logic [31:0] m_tbl [NB];
  logic [15:0] m_ring [NR];
  bit          m_uf;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      mon_it = sb_q.pop_front();
      case (mon_it.kind)
        0:       mon_got = tbl_rdata_o;
        1:       mon_got = {16'h0, ring_cnt_o};
        default: mon_got = {31'h0, underflow_o};
      endcase
      checks++;
      if (mon_it.due != cyc || mon_got !== mon_it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", mon_it.tag, mon_it.kind,
                 mon_got, mon_it.exp);
      end
    end
  end

  function automatic logic [39:0] mk_addr(int dom, int region, int ring, int bkt,
                                          bit ren, bit ben);
    return (40'(dom) << 35) | (40'(region) << 26) | (40'(ben) << 25) |
           (40'(ren) << 24) | (40'(bkt) << 11) | (40'(ring) << 3);
  endfunction

  task automatic model_upd(inout logic [15:0] c, input bit i, input logic [15:0] r);
    int s;
    s = int'(c) + int'(i);
    if (s < int'(r)) begin
      c = '0;
      m_uf = 1'b1;
    end else begin
      s = s - int'(r);
      c = (s > 65535) ? 16'hFFFF : 16'(s);
    end
  endtask

  task automatic drive(bit wr, int dom, int region, int ring, int bkt, bit ren, bit ben,
                       logic [15:0] cnt, bit inc, int ib, int ir,
                       bit twe, int ti, logic [31:0] td);
    bit acc;
    logic [15:0] c;
    acc = wr && region == 4 && (ren || ben) && dom_en_i[dom];
    for (int b = 0; b < NB; b++) begin
      if (twe && ti == b) m_tbl[b] = td;
      else begin
        c = m_tbl[b][23:8];
        model_upd(c, inc && ib == b, (acc && ben && bkt == b) ? cnt : 16'h0);
        m_tbl[b][23:8] = c;
      end
    end
    for (int r = 0; r < NR; r++)
      model_upd(m_ring[r], inc && ir == r, (acc && ren && ring == r) ? cnt : 16'h0);
    mmio_wr_i   = wr;
    mmio_addr_i = mk_addr(dom, region, ring, bkt, ren, ben);
    mmio_data_i = {48'hDEAD_BEEF_5A5A, cnt};
    inc_i       = inc;
    inc_bkt_i   = 4'(ib);
    inc_ring_i  = 3'(ir);
    tbl_we_i    = twe;
    tbl_idx_i   = 4'(ti);
    tbl_wdata_i = td;
    @(negedge clk);
    mmio_wr_i = 1'b0;
    inc_i     = 1'b0;
    tbl_we_i  = 1'b0;
  endtask

  task automatic store(int dom, int region, int ring, int bkt, bit ren, bit ben,
                       logic [15:0] cnt);
    drive(1, dom, region, ring, bkt, ren, ben, cnt, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic bump(int ib, int ir);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, ib, ir, 0, 0, 0);
  endtask

  task automatic twr(int ti, logic [31:0] td);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ti, td);
  endtask

  task automatic rd(int b, int r, string tag);
    item_t it;
    tbl_idx_i  = 4'(b);
    ring_sel_i = 3'(r);
    it.due = cyc + 1; it.kind = 0; it.exp = m_tbl[b];           it.tag = tag; sb_q.push_back(it);
    it.due = cyc + 1; it.kind = 1; it.exp = {16'h0, m_ring[r]}; it.tag = tag; sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic ufchk(string tag);
    item_t it;
    it.due = cyc + 1; it.kind = 2; it.exp = {31'h0, m_uf}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) m_tbl[b] = '0;
    for (int r = 0; r < NR; r++) m_ring[r] = '0;
    m_uf = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(0, 0, "R11");
    rd(NB-1, NR-1, "R11");
    ufchk("R11");

    // R6 increments, R10 ring read
    repeat (5) bump(3, 2);
    repeat (3) bump(5, 7);
    repeat (2) bump(0, 0);
    rd(3, 2, "R6");
    rd(5, 7, "R10");

    // R4 / R1 bucket only, ring only, both
    store(1, 4, 2, 3, 0, 1, 16'd2);
    rd(3, 2, "R4");
    store(1, 4, 2, 3, 1, 0, 16'd1);
    rd(3, 2, "R4");
    store(2, 4, 7, 5, 1, 1, 16'd2);
    rd(5, 7, "R1");

    // R2 wrong region
    store(1, 5, 2, 3, 1, 1, 16'd1);
    store(1, 0, 2, 3, 1, 1, 16'd1);
    store(1, 6, 2, 3, 1, 1, 16'd1);
    rd(3, 2, "R2");
    ufchk("R2");

    // R3 no enables
    store(1, 4, 2, 3, 0, 0, 16'd1);
    rd(3, 2, "R3");

    // R5 domain mask
    store(0, 4, 2, 3, 1, 1, 16'd1);
    store(9, 4, 2, 3, 1, 1, 16'd1);
    rd(3, 2, "R5");
    store(31, 4, 2, 3, 1, 1, 16'd1);
    rd(3, 2, "R5");

    // R8 same-cycle increment and release
    drive(1, 1, 4, 7, 5, 1, 1, 16'd1, 1, 5, 7, 0, 0, 0);
    rd(5, 7, "R8");
    drive(1, 1, 4, 6, 6, 1, 1, 16'd1, 1, 6, 6, 0, 0, 0);
    rd(6, 6, "R8");
    ufchk("R8");

    // R12 out-of-range indexes must not alias onto index 0
    store(1, 4, NR, NB, 1, 1, 16'd1);
    rd(0, 0, "R12");
    ufchk("R12");

    // R9 entry layout, write priority
    twr(7, 32'hB101_02AB);
    rd(7, 0, "R9");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 1, 1, 7, 32'h0000_0500);
    rd(7, 1, "R9");

    // R6 bucket saturation at all ones
    twr(8, 32'h00FF_FF00);
    bump(8, 0);
    rd(8, 0, "R6");

    // R7 underflow floor and sticky flag
    store(1, 4, 2, 3, 1, 1, 16'd100);
    rd(3, 2, "R7");
    ufchk("R7");
    bump(3, 2);
    ufchk("R7");
    rd(3, 2, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule